// File: doc/BRIEF.md
# Shadow-Register Change Scheduler

This block keeps two copies of a 25-entry, 8-bit register file for each of two sound chips, a left one and a right one. The main copy is what the host wants the chip to hold. The shadow copy is what has already been sent. The host writes main entries through a single write port. On a scan trigger, the block walks all entries in a fixed order and compares main against shadow for both chips. For every mismatch it raises a write request (address, data, target) towards a downstream serial writer and waits for that writer to accept it. The shadow copy is updated in the same cycle the request is accepted.

The walk visits the oscillator and envelope registers of all three voices before any voice control register. This keeps the gate bits from being sent ahead of the pitch they act on. The control registers follow, and the four global filter and volume registers come last.

Entries that changed in the same way in both chips, starting from equal shadows, are sent as one request addressed to both chips. A refresh command forces every entry to be sent again, in two passes: the first pass has the oscillator test bit set in every voice control register, and the second has it cleared. A disable input blocks triggered scans.

Top module: `dual_shadow_sched`

## Requirements
- R1: After reset every main and shadow entry of both chips is 0x00, `req_valid` and `scan_done` are low, and a scan started with no host writes issues no request.
- R2: When, at the entry being scanned, the left and right main values are equal, the left and right shadows are equal, and main differs from shadow, exactly one request is issued, with `req_target` = 2'b11 and the main value as data.
- R3: Otherwise a request with `req_target` = 2'b01 is issued if the left main differs from its shadow, followed by one with `req_target` = 2'b10 if the right main differs from its shadow; data is that chip's main value.
- R4: A scan visits addresses in this order: 0,1,2,3,5,6, 7,8,9,10,12,13, 14,15,16,17,19,20 (the three voices without their control registers), then the control registers 4, 11 and 18, then 21, 22, 23 and 24.
- R5: The shadow entry for a target takes the issued value in the cycle the request is accepted (`req_valid` and `req_ready` both high), so a scan that follows with no host writes issues no request.
- R6: While `req_valid` is high and `req_ready` is low, and no host write occurs, `req_valid`, `req_addr`, `req_data` and `req_target` hold their values.
- R7: A refresh sets every shadow to main+1 (modulo 256) and sets bit 3 of the control entries 4, 11 and 18 of both chips, then runs a full scan. It then clears that bit 3 and runs a second full scan.
- R8: `scan_done` is a single-cycle pulse at the end of every full scan; a refresh yields two pulses.
- R9: While `scan_disable` is high, `scan_start` is ignored; a refresh still runs.
- R10: A host write (`host_sel` 0 = left, 1 = right) is accepted in any cycle, including during a scan. An entry not yet compared in the running scan is compared against its new value.
- R11: `scan_start` and `refresh` are ignored while a scan is running; when both arrive in an idle cycle, refresh wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host main-entry write strobe |
| host_sel | input | 1 | Chip selected by the host write: 0 left, 1 right |
| host_addr | input | 5 | Entry address of the host write |
| host_data | input | 8 | Value of the host write |
| scan_start | input | 1 | Starts one full scan when idle |
| refresh | input | 1 | Starts the two-pass forced rewrite when idle |
| scan_disable | input | 1 | Blocks `scan_start` |
| req_ready | input | 1 | Downstream writer accepts the current request |
| req_valid | output | 1 | A write request is presented |
| req_addr | output | 5 | Entry address of the request |
| req_data | output | 8 | Value to write |
| req_target | output | 2 | Bit 0 left chip, bit 1 right chip |
| scan_done | output | 1 | One-cycle pulse at the end of each full scan |

## Verification
The bench builds the block with its default parameters: 8-bit data, three voices with a stride of seven entries, the control register at offset four, and test bit three. These are the only values for which the fixed visiting order and the 25-entry layout hold. With them, every position of the walk can be exercised: the control registers that are deferred, the merged writes, the split left-then-right writes, and the two refresh passes. Ready is driven high, held low, and toggled every other cycle. Holding ready low stalls a scan, which makes the busy-time triggers and the mid-scan host writes reachable.

// File: rtl/shsched_pkg.sv
package shsched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1
    } scan_state_e;

    localparam logic [1:0] TGT_LEFT  = 2'b01;
    localparam logic [1:0] TGT_RIGHT = 2'b10;
    localparam logic [1:0] TGT_BOTH  = 2'b11;

endpackage

// File: rtl/shsched_bank.sv
module shsched_bank #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 5,
    parameter int NUM_VOICES   = 3,
    parameter int VOICE_STRIDE = 7,
    parameter int CTRL_OFS     = 4,
    parameter int TEST_BIT     = 3,
    parameter int NUM_ENTRIES  = NUM_VOICES * VOICE_STRIDE + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] main_rd,
    output logic [DATA_W-1:0] shadow_rd,
    input  logic              commit,
    input  logic              bump,
    input  logic              test_set,
    input  logic              test_clr
);

    logic [DATA_W-1:0] main_q   [NUM_ENTRIES];
    logic [DATA_W-1:0] main_d   [NUM_ENTRIES];
    logic [DATA_W-1:0] shadow_q [NUM_ENTRIES];
    logic [DATA_W-1:0] shadow_d [NUM_ENTRIES];

    assign main_rd   = main_q[rd_addr];
    assign shadow_rd = shadow_q[rd_addr];

    always_comb begin
        main_d   = main_q;
        shadow_d = shadow_q;
        if (bump) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                shadow_d[i] = main_q[i] + DATA_W'(1);
            end
        end
        if (commit) begin
            shadow_d[rd_addr] = main_q[rd_addr];
        end
        for (int v = 0; v < NUM_VOICES; v++) begin
            if (test_set) main_d[v * VOICE_STRIDE + CTRL_OFS][TEST_BIT] = 1'b1;
            if (test_clr) main_d[v * VOICE_STRIDE + CTRL_OFS][TEST_BIT] = 1'b0;
        end
        if (host_we && (32'(host_addr) < NUM_ENTRIES)) begin
            main_d[host_addr] = host_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                main_q[i]   <= '0;
                shadow_q[i] <= '0;
            end
        end else begin
            main_q   <= main_d;
            shadow_q <= shadow_d;
        end
    end

    // R5: an accepted write leaves the shadow holding the value that was sent
    assert_shadow_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !bump |=> shadow_q[$past(rd_addr)] == $past(main_rd));

    // R7: a refresh bump leaves every shadow one above its old main value
    assert_refresh_bump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bump && !host_we |=> shadow_q[0] == $past(main_q[0]) + DATA_W'(1));

endmodule

// File: rtl/shsched_scan.sv
module shsched_scan
    import shsched_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 5,
    parameter int NUM_VOICES   = 3,
    parameter int VOICE_STRIDE = 7,
    parameter int CTRL_OFS     = 4,
    parameter int NUM_ENTRIES  = NUM_VOICES * VOICE_STRIDE + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic              refresh,
    input  logic              scan_disable,
    input  logic              host_we,
    input  logic [DATA_W-1:0] main_l,
    input  logic [DATA_W-1:0] main_r,
    input  logic [DATA_W-1:0] shadow_l,
    input  logic [DATA_W-1:0] shadow_r,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              req_valid,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]        req_target,
    output logic              commit_l,
    output logic              commit_r,
    output logic              bump,
    output logic              test_set,
    output logic              test_clr,
    output logic              scan_done
);

    localparam int POS_W         = $clog2(NUM_ENTRIES);
    localparam int OSC_PER_VOICE = VOICE_STRIDE - 1;
    localparam int OSC_TOTAL     = NUM_VOICES * OSC_PER_VOICE;
    localparam int CTRL_END      = NUM_VOICES * VOICE_STRIDE;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_ENTRIES - 1);

    typedef struct packed {
        scan_state_e      state;
        logic [POS_W-1:0] pos;
        logic             first_pass;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic need_l, need_r, merge;

    // Scan position to entry address: voice oscillator/envelope entries,
    // then the voice control entries, then the global entries.
    function automatic logic [ADDR_W-1:0] order_addr(input int unsigned p);
        int unsigned a;
        if (p < OSC_TOTAL) begin
            a = (p / OSC_PER_VOICE) * VOICE_STRIDE + (p % OSC_PER_VOICE);
            if ((p % OSC_PER_VOICE) >= CTRL_OFS) a = a + 1;
        end else if (p < CTRL_END) begin
            a = (p - OSC_TOTAL) * VOICE_STRIDE + CTRL_OFS;
        end else begin
            a = p;
        end
        return a[ADDR_W-1:0];
    endfunction

    assign rd_addr = order_addr(32'(ctl_q.pos));

    always_comb begin
        ctl_d     = ctl_q;
        bump      = 1'b0;
        test_set  = 1'b0;
        test_clr  = 1'b0;
        scan_done = 1'b0;
        commit_l  = 1'b0;
        commit_r  = 1'b0;
        need_l    = main_l != shadow_l;
        need_r    = main_r != shadow_r;
        merge     = (main_l == main_r) && (shadow_l == shadow_r) && need_l;
        req_valid = (ctl_q.state == ST_SCAN) && (need_l || need_r);
        req_target = merge ? TGT_BOTH : (need_l ? TGT_LEFT : TGT_RIGHT);
        req_data   = need_l ? main_l : main_r;

        case (ctl_q.state)
            ST_IDLE: begin
                if (refresh) begin
                    bump             = 1'b1;
                    test_set         = 1'b1;
                    ctl_d.state      = ST_SCAN;
                    ctl_d.pos        = '0;
                    ctl_d.first_pass = 1'b1;
                end else if (scan_start && !scan_disable) begin
                    ctl_d.state      = ST_SCAN;
                    ctl_d.pos        = '0;
                    ctl_d.first_pass = 1'b0;
                end
            end
            ST_SCAN: begin
                if (req_valid) begin
                    commit_l = req_ready && req_target[0];
                    commit_r = req_ready && req_target[1];
                end else if (ctl_q.pos == LAST_POS) begin
                    scan_done = 1'b1;
                    ctl_d.pos = '0;
                    if (ctl_q.first_pass) begin
                        test_clr         = 1'b1;
                        ctl_d.first_pass = 1'b0;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end else begin
                    ctl_d.pos = ctl_q.pos + 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, pos: '0, first_pass: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R6: a stalled request holds its fields
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !host_we |=>
            req_valid && $stable(rd_addr) && $stable(req_data) && $stable(req_target));

    // R2: a merged write clears the need of its entry for both chips
    assert_merge_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_target == TGT_BOTH) && !host_we |=>
            !(req_valid && (rd_addr == $past(rd_addr))));

    // R3: a right-only request appears only once the left entry is in step
    assert_right_after_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_target == TGT_RIGHT) |-> main_l == shadow_l);

    // R8: end-of-scan indication lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R9: a disabled trigger leaves the block idle
    assert_disable_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE) && scan_start && scan_disable && !refresh |=>
            ctl_q.state == ST_IDLE);

endmodule

// File: rtl/dual_shadow_sched.sv
module dual_shadow_sched #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 5,
    parameter int NUM_VOICES   = 3,
    parameter int VOICE_STRIDE = 7,
    parameter int CTRL_OFS     = 4,
    parameter int TEST_BIT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              scan_start,
    input  logic              refresh,
    input  logic              scan_disable,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]        req_target,
    output logic              scan_done
);

    localparam int NUM_ENTRIES = NUM_VOICES * VOICE_STRIDE + 4;
    localparam int NUM_CHIPS   = 2;

    logic [ADDR_W-1:0]    rd_addr;
    logic [DATA_W-1:0]    main_rd   [NUM_CHIPS];
    logic [DATA_W-1:0]    shadow_rd [NUM_CHIPS];
    logic [NUM_CHIPS-1:0] commit;
    logic                 bump, test_set, test_clr;

    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        shsched_bank #(
            .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_VOICES(NUM_VOICES),
            .VOICE_STRIDE(VOICE_STRIDE), .CTRL_OFS(CTRL_OFS),
            .TEST_BIT(TEST_BIT), .NUM_ENTRIES(NUM_ENTRIES)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .host_we   (host_we && (host_sel == 1'(c))),
            .host_addr (host_addr),
            .host_data (host_data),
            .rd_addr   (rd_addr),
            .main_rd   (main_rd[c]),
            .shadow_rd (shadow_rd[c]),
            .commit    (commit[c]),
            .bump      (bump),
            .test_set  (test_set),
            .test_clr  (test_clr)
        );
    end

    shsched_scan #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_VOICES(NUM_VOICES),
        .VOICE_STRIDE(VOICE_STRIDE), .CTRL_OFS(CTRL_OFS), .NUM_ENTRIES(NUM_ENTRIES)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_start   (scan_start),
        .refresh      (refresh),
        .scan_disable (scan_disable),
        .host_we      (host_we),
        .main_l       (main_rd[0]),
        .main_r       (main_rd[1]),
        .shadow_l     (shadow_rd[0]),
        .shadow_r     (shadow_rd[1]),
        .req_ready    (req_ready),
        .rd_addr      (rd_addr),
        .req_valid    (req_valid),
        .req_data     (req_data),
        .req_target   (req_target),
        .commit_l     (commit[0]),
        .commit_r     (commit[1]),
        .bump         (bump),
        .test_set     (test_set),
        .test_clr     (test_clr),
        .scan_done    (scan_done)
    );

    assign req_addr = rd_addr;

endmodule

// File: tb/dual_shadow_sched_tb.sv
`timescale 1ns/1ps
module dual_shadow_sched_tb;

    localparam int NE = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0, host_sel = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_data = '0;
    logic       scan_start = 1'b0, refresh = 1'b0, scan_disable = 1'b0;
    logic       req_ready = 1'b1;
    logic       req_valid, scan_done;
    logic [4:0] req_addr;
    logic [7:0] req_data;
    logic [1:0] req_target;

    always #2 clk = ~clk;

    dual_shadow_sched u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_addr(host_addr), .host_data(host_data), .scan_start(scan_start),
        .refresh(refresh), .scan_disable(scan_disable), .req_ready(req_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_target(req_target), .scan_done(scan_done)
    );

    int checks = 0, errors = 0;
    int done_cnt = 0, seen = 0, ready_mode = 1, cyc = 0;
    bit finished = 1'b0;
    logic [7:0] mm [2][NE];
    logic [7:0] ms [2][NE];
    logic [14:0] exp_q [$];
    int order [NE] = '{0,1,2,3,5,6,7,8,9,10,12,13,14,15,16,17,19,20,4,11,18,21,22,23,24};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ready pattern: 0 held low, 1 high, 2 toggling
    always begin
        @(posedge clk);
        cyc++;
        #1;
        req_ready = (ready_mode == 1) || (ready_mode == 2 && (cyc % 2 == 0));
    end

    // monitor / scoreboard
    bit prev_done = 1'b0, hold_chk = 1'b0;
    logic [14:0] hold_item;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scan_done) begin
                done_cnt++;
                if (prev_done) chk(1'b0, "R8 done wider than one cycle", 1, 0);
            end
            prev_done = scan_done;
            if (hold_chk)
                chk(req_valid && {req_addr, req_data, req_target} == hold_item,
                    "R6 stalled request changed", {req_valid, req_addr, req_data, req_target},
                    {1'b1, hold_item});
            hold_chk  = req_valid && !req_ready && !host_we;
            hold_item = {req_addr, req_data, req_target};
            if (req_valid && req_ready) begin
                seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R3/R5 unexpected request", {req_addr, req_data, req_target}, 0);
                end else begin
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    chk({req_addr, req_data, req_target} == e,
                        "R2/R3/R4 request {addr,data,target}", {req_addr, req_data, req_target}, e);
                end
            end
        end
    end

    task automatic host_wr(input bit sel, input int a, input logic [7:0] d);
        @(posedge clk); #1;
        host_we = 1'b1; host_sel = sel; host_addr = 5'(a); host_data = d;
        @(posedge clk); #1;
        host_we = 1'b0;
        mm[sel][a] = d;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1; scan_start = 1'b1;
        @(posedge clk); #1; scan_start = 1'b0;
    endtask

    task automatic pulse_refresh();
        @(posedge clk); #1; refresh = 1'b1;
        @(posedge clk); #1; refresh = 1'b0;
    endtask

    // expected requests of one scan, from the requirement rules
    task automatic push_scan();
        for (int i = 0; i < NE; i++) begin
            int a;
            a = order[i];
            if (mm[0][a] == mm[1][a] && ms[0][a] == ms[1][a] && mm[0][a] != ms[0][a]) begin
                exp_q.push_back({5'(a), mm[0][a], 2'b11});
                ms[0][a] = mm[0][a]; ms[1][a] = mm[1][a];
            end else begin
                if (mm[0][a] != ms[0][a]) begin
                    exp_q.push_back({5'(a), mm[0][a], 2'b01});
                    ms[0][a] = mm[0][a];
                end
                if (mm[1][a] != ms[1][a]) begin
                    exp_q.push_back({5'(a), mm[1][a], 2'b10});
                    ms[1][a] = mm[1][a];
                end
            end
        end
    endtask

    task automatic wait_done(input int n);
        while (done_cnt < n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        int d0, s0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < NE; i++) begin mm[c][i] = 8'h00; ms[c][i] = 8'h00; end

        // R1 reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid, "R1 req_valid after reset", req_valid, 0);
        chk(!scan_done, "R1 scan_done after reset", scan_done, 0);
        s0 = seen;
        push_scan();
        pulse_start();
        wait_done(1);
        chk(seen == s0, "R1 requests from reset contents", seen - s0, 0);

        // R2/R3/R4 mixed merge and split writes
        host_wr(0, 0, 8'h11); host_wr(1, 0, 8'h11);
        host_wr(0, 5, 8'h22);
        host_wr(1, 7, 8'h33);
        host_wr(0, 9, 8'h44); host_wr(1, 9, 8'h55);
        host_wr(0, 4, 8'h41); host_wr(1, 4, 8'h41);
        host_wr(0, 24, 8'h01); host_wr(1, 24, 8'h01);
        push_scan();
        pulse_start();
        wait_done(2);
        chk(exp_q.size() == 0, "R3 pending expected requests", exp_q.size(), 0);

        // R5 rescan without changes issues nothing
        s0 = seen;
        push_scan();
        pulse_start();
        wait_done(3);
        chk(seen == s0, "R5 requests after shadows caught up", seen - s0, 0);

        // R4/R6 every entry changed, toggling ready
        ready_mode = 2;
        for (int i = 0; i < NE; i++) begin
            host_wr(0, i, 8'(i * 3 + 8'h80));
            host_wr(1, i, 8'(i * 3 + 8'h80));
        end
        push_scan();
        pulse_start();
        wait_done(4);
        chk(exp_q.size() == 0, "R4 full-order scan incomplete", exp_q.size(), 0);
        ready_mode = 1;

        // R9 disabled trigger ignored
        scan_disable = 1'b1;
        host_wr(0, 2, 8'h99);
        d0 = done_cnt; s0 = seen;
        pulse_start();
        repeat (40) @(negedge clk);
        chk(done_cnt == d0, "R9 scan ran while disabled", done_cnt - d0, 0);
        chk(seen == s0, "R9 request while disabled", seen - s0, 0);

        // R7/R8/R9 refresh runs even when disabled; two passes
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < NE; i++) ms[c][i] = mm[c][i] + 8'h01;
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 3; v++) mm[c][v * 7 + 4][3] = 1'b1;
        push_scan();
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 3; v++) mm[c][v * 7 + 4][3] = 1'b0;
        push_scan();
        pulse_refresh();
        wait_done(d0 + 2);
        chk(exp_q.size() == 0, "R7 refresh passes incomplete", exp_q.size(), 0);
        repeat (10) @(negedge clk);
        chk(done_cnt == d0 + 2, "R8 refresh done pulse count", done_cnt - d0, 2);
        scan_disable = 1'b0;

        // R10/R11 writes and triggers during a stalled scan
        ready_mode = 0;
        host_wr(0, 0, 8'h5A);
        d0 = done_cnt;
        pulse_start();
        repeat (4) @(negedge clk);
        chk(req_valid && req_addr == 5'd0, "R6 stalled at entry 0", {req_valid, req_addr}, {1'b1, 5'd0});
        host_wr(0, 24, 8'h6B);
        host_wr(1, 12, 8'h7C);
        pulse_refresh();
        pulse_start();
        push_scan();
        ready_mode = 1;
        wait_done(d0 + 1);
        chk(exp_q.size() == 0, "R10 mid-scan writes not sent", exp_q.size(), 0);
        s0 = seen;
        repeat (40) @(negedge clk);
        chk(done_cnt == d0 + 1, "R11 busy-time trigger acted", done_cnt - d0, 1);
        chk(seen == s0, "R11 requests after busy-time trigger", seen - s0, 0);

        summary();
    end

endmodule